// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The walker steps through transmit descriptors that software has placed in memory for an Ethernet MAC DMA engine. Each descriptor is four 32-bit words. The walker reads them in order through a simple request/acknowledge read port and checks the ownership flag in word 0 first. If the DMA owns the descriptor, the walker reads the other three words. It then hands both buffer addresses, both lengths and the first/last segment markers to a downstream data fetcher. When the fetcher reports that the buffer has been read, the walker writes word 0 back with ownership released and an error summary bit folded in. It then moves on to the next descriptor.

The next descriptor address comes from one of three sources. In plain ring mode it is the current address plus the descriptor size. An end-of-ring flag sends it back to the list base. A chained flag takes it from word 3 instead. A descriptor that the DMA does not own stops the walk and raises a buffer-unavailable level. The walk then waits for a poll-demand pulse and reads the same descriptor again.

Top module: `txdesc_walker`

## Requirements
- R1: A `start` pulse while idle begins the walk at `base_addr`. The four words of a descriptor are read in ascending order at byte offsets 0, 4, 8 and 12 from the descriptor address, and each read address is word aligned.
- R2: Word 0 bit 31 is the ownership flag. When it reads as 0, the walker reads no further words of that descriptor, issues no segment and no write. It then holds `buf_unavail` high until a `poll_demand` pulse, after which it reads word 0 of the same descriptor again.
- R3: For an owned descriptor, the walker presents one segment. Buffer 1 address is word 2, buffer 1 length is word 1 bits [12:0], buffer 2 address is word 3, and buffer 2 length is word 1 bits [28:16]. `seg_first` is word 0 bit 28 and `seg_last` is word 0 bit 29. All of these hold steady while `seg_valid` waits for `seg_ready`.
- R4: Chaining is in effect when word 0 bit 20 and bit 28 are both set and bit 21 is clear. In that case the buffer 2 length is presented as 0, and the next descriptor is read from the address held in word 3.
- R5: When word 0 bit 21 is set, the next descriptor address is the list base, whatever the state of bit 20.
- R6: When neither bit 21 nor effective chaining applies, the next descriptor address is the current one plus 16. This includes the case where bit 20 is set without bit 28, and then buffer 2 length is passed through unchanged.
- R7: After `xfer_done`, exactly one write is made to word 0 of the current descriptor. In the written word, bit 31 is cleared and bit 15 equals the OR of `xfer_err`; all other bits keep their fetched values.
- R8: `tx_irq` is a one-cycle pulse in the cycle after the write-back is acknowledged. It fires only when word 0 bit 30 and bit 29 are both set.
- R9: A `poll_demand` pulse has no effect unless the walker is already suspended. This holds even for a pulse that coincides with the read returning a non-owned word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking at base_addr (idle only) |
| base_addr | input | AW | List base address |
| poll_demand | input | 1 | Resume pulse while suspended |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor read byte address |
| rd_ack | input | 1 | Read data valid, completes request |
| rd_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offered to the fetcher |
| seg_ready | input | 1 | Fetcher accepts segment |
| seg_first | output | 1 | Segment starts a frame |
| seg_last | output | 1 | Segment ends a frame |
| seg_buf1_addr | output | AW | Buffer 1 address |
| seg_buf1_len | output | LEN_W | Buffer 1 length |
| seg_buf2_addr | output | AW | Buffer 2 address |
| seg_buf2_len | output | LEN_W | Buffer 2 length (0 when chained) |
| xfer_done | input | 1 | Fetcher finished reading the segment buffers |
| xfer_err | input | ERR_W | Error bits reported with xfer_done |
| wr_req | output | 1 | Status write-back request |
| wr_addr | output | AW | Write-back byte address |
| wr_data | output | 32 | Write-back word 0 |
| wr_ack | input | 1 | Write accepted |
| tx_irq | output | 1 | Completion interrupt pulse |
| buf_unavail | output | 1 | Suspended on a non-owned descriptor |
| busy | output | 1 | Walker is not idle |

## Verification
A resume request and the ownership test can fall in the same cycle. This happens when `poll_demand` is high exactly in the cycle in which the read port returns a non-owned word 0. The bench first resumes a suspended walker onto a descriptor that is still not owned. It drives the second pulse at the negative edge of that read's acknowledge cycle. It then judges the outcome by counting read requests over the following cycles, expecting none, and by requiring `buf_unavail` to stay high. A later legitimate pulse must still resume the walk.

// File: rtl/txw_pkg.sv
package txw_pkg;
   localparam int OWN_B = 31;
   localparam int IC_B  = 30;
   localparam int LS_B  = 29;
   localparam int FS_B  = 28;
   localparam int EOR_B = 21;
   localparam int CHN_B = 20;
   localparam int ES_B  = 15;
   localparam int LEN2_LSB = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SUSP,
      ST_ISSUE,
      ST_WAIT,
      ST_WB
   } walk_st_t;

   typedef struct packed {
      logic own;
      logic ic;
      logic ls;
      logic fs;
      logic eor;
      logic chn;
   } dflags_t;

   function automatic dflags_t decode_w0(input logic [31:0] w);
      dflags_t f;
      f.own = w[OWN_B];
      f.ic  = w[IC_B];
      f.ls  = w[LS_B];
      f.fs  = w[FS_B];
      f.eor = w[EOR_B];
      f.chn = w[CHN_B];
      return f;
   endfunction
endpackage

// File: rtl/txw_fetch.sv
module txw_fetch
   import txw_pkg::*;
#(
   parameter int AW = 32,
   parameter int NW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] go_addr,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [31:0]   rd_data,
   output logic [31:0]   words [NW],
   output logic          done,
   output logic          not_owned
);
   localparam int IW = (NW > 1) ? $clog2(NW) : 1;

   logic          active;
   logic [IW-1:0] idx;
   logic [AW-1:0] dbase;

   assign rd_req  = active;
   assign rd_addr = dbase + AW'({idx, 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         idx       <= '0;
         dbase     <= '0;
         done      <= 1'b0;
         not_owned <= 1'b0;
      end else begin
         done      <= 1'b0;
         not_owned <= 1'b0;
         if (go) begin
            active <= 1'b1;
            idx    <= '0;
            dbase  <= go_addr;
         end else if (active && rd_ack) begin
            if (idx == '0 && !rd_data[OWN_B]) begin
               active    <= 1'b0;
               not_owned <= 1'b1;
            end else if (idx == IW'(NW-1)) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words[g] <= '0;
         end else if (active && rd_ack && idx == IW'(g)) begin
            words[g] <= rd_data;
         end
      end
   end
endmodule

// File: rtl/txw_next.sv
module txw_next
   import txw_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 16,
   parameter bit CHAIN_EN   = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] base,
   input  logic [31:0]   w0,
   input  logic [31:0]   w3,
   output logic [AW-1:0] nxt,
   output logic          chain_eff
);
   dflags_t f;
   assign f = decode_w0(w0);

   if (CHAIN_EN) begin : g_chain
      assign chain_eff = f.fs && f.chn && !f.eor;
   end else begin : g_nochain
      assign chain_eff = 1'b0;
   end

   always_comb begin
      if (f.eor)
         nxt = base;
      else if (chain_eff)
         nxt = w3[AW-1:0];
      else
         nxt = cur + AW'(DESC_BYTES);
   end
endmodule

// File: rtl/txw_wb.sv
module txw_wb
   import txw_pkg::*;
#(
   parameter int ERR_W = 4
) (
   input  logic [31:0]      w0,
   input  logic [ERR_W-1:0] err,
   output logic [31:0]      wb_word,
   output logic             irq_req
);
   dflags_t f;
   assign f = decode_w0(w0);

   always_comb begin
      wb_word        = w0;
      wb_word[OWN_B] = 1'b0;
      wb_word[ES_B]  = |err;
   end

   assign irq_req = f.ic && f.ls;
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
   import txw_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LEN_W      = 13,
   parameter int ERR_W      = 4,
   parameter int DESC_BYTES = 16,
   parameter bit CHAIN_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    base_addr,
   input  logic             poll_demand,
   output logic             rd_req,
   output logic [AW-1:0]    rd_addr,
   input  logic             rd_ack,
   input  logic [31:0]      rd_data,
   output logic             seg_valid,
   input  logic             seg_ready,
   output logic             seg_first,
   output logic             seg_last,
   output logic [AW-1:0]    seg_buf1_addr,
   output logic [LEN_W-1:0] seg_buf1_len,
   output logic [AW-1:0]    seg_buf2_addr,
   output logic [LEN_W-1:0] seg_buf2_len,
   input  logic             xfer_done,
   input  logic [ERR_W-1:0] xfer_err,
   output logic             wr_req,
   output logic [AW-1:0]    wr_addr,
   output logic [31:0]      wr_data,
   input  logic             wr_ack,
   output logic             tx_irq,
   output logic             buf_unavail,
   output logic             busy
);
   localparam int NW = 4;

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("txdesc_walker: AW must lie in 8..32");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("txdesc_walker: LEN_W must lie in 1..16");
   end
   if (ERR_W < 1) begin : g_bad_err
      $error("txdesc_walker: ERR_W must be at least 1");
   end
   if (DESC_BYTES < NW * 4 || (DESC_BYTES % 4) != 0) begin : g_bad_sz
      $error("txdesc_walker: DESC_BYTES must be a word multiple of at least 16");
   end

   walk_st_t         st;
   logic [AW-1:0]    cur;
   logic [AW-1:0]    base_r;
   logic [ERR_W-1:0] err_r;

   logic             go;
   logic [AW-1:0]    go_addr;
   logic [31:0]      words [NW];
   logic             f_done;
   logic             f_not_owned;
   logic [AW-1:0]    nxt;
   logic             chain_eff;
   logic [31:0]      wb_word;
   logic             irq_req;

   always_comb begin
      go      = 1'b0;
      go_addr = cur;
      unique case (st)
         ST_IDLE: begin
            go      = start;
            go_addr = base_addr;
         end
         ST_SUSP: go = poll_demand;
         ST_WB: begin
            go      = wr_ack;
            go_addr = nxt;
         end
         default: go = 1'b0;
      endcase
   end

   txw_fetch #(.AW(AW), .NW(NW)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_addr   (go_addr),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_ack    (rd_ack),
      .rd_data   (rd_data),
      .words     (words),
      .done      (f_done),
      .not_owned (f_not_owned)
   );

   txw_next #(.AW(AW), .DESC_BYTES(DESC_BYTES), .CHAIN_EN(CHAIN_EN)) u_next (
      .cur       (cur),
      .base      (base_r),
      .w0        (words[0]),
      .w3        (words[3]),
      .nxt       (nxt),
      .chain_eff (chain_eff)
   );

   txw_wb #(.ERR_W(ERR_W)) u_wb (
      .w0      (words[0]),
      .err     (err_r),
      .wb_word (wb_word),
      .irq_req (irq_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cur    <= '0;
         base_r <= '0;
         err_r  <= '0;
         tx_irq <= 1'b0;
      end else begin
         tx_irq <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               cur    <= base_addr;
               base_r <= base_addr;
               st     <= ST_FETCH;
            end
            ST_FETCH: begin
               if (f_not_owned)
                  st <= ST_SUSP;
               else if (f_done)
                  st <= ST_ISSUE;
            end
            ST_SUSP: if (poll_demand) st <= ST_FETCH;
            ST_ISSUE: if (seg_ready) st <= ST_WAIT;
            ST_WAIT: if (xfer_done) begin
               err_r <= xfer_err;
               st    <= ST_WB;
            end
            ST_WB: if (wr_ack) begin
               tx_irq <= irq_req;
               cur    <= nxt;
               st     <= ST_FETCH;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign seg_valid     = (st == ST_ISSUE);
   assign seg_first     = words[0][FS_B];
   assign seg_last      = words[0][LS_B];
   assign seg_buf1_addr = words[2][AW-1:0];
   assign seg_buf1_len  = words[1][LEN_W-1:0];
   assign seg_buf2_addr = words[3][AW-1:0];
   assign seg_buf2_len  = chain_eff ? '0 : words[1][LEN2_LSB +: LEN_W];

   assign wr_req      = (st == ST_WB);
   assign wr_addr     = cur;
   assign wr_data     = wb_word;
   assign buf_unavail = (st == ST_SUSP);
   assign busy        = (st != ST_IDLE);
endmodule

// File: rtl/txw_chk.sv
module txw_chk #(
   parameter int AW    = 32,
   parameter int LEN_W = 13,
   parameter int ERR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             poll_demand,
   input logic             rd_req,
   input logic [AW-1:0]    rd_addr,
   input logic             seg_valid,
   input logic             seg_ready,
   input logic [AW-1:0]    seg_buf1_addr,
   input logic [LEN_W-1:0] seg_buf1_len,
   input logic             wr_req,
   input logic             wr_ack,
   input logic [31:0]      wr_data,
   input logic             tx_irq,
   input logic             buf_unavail
);
   // R1
   rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> rd_addr[1:0] == 2'b00);

   // R2
   susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_unavail |-> !seg_valid && !rd_req && !wr_req);

   // R3
   seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !seg_ready |=> seg_valid && $stable(seg_buf1_addr) && $stable(seg_buf1_len));

   // R7
   wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !wr_data[31]);

   // R8
   irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> $past(wr_req && wr_ack));

   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);

   // R9
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_unavail && !poll_demand |=> buf_unavail);
endmodule

bind txdesc_walker txw_chk #(.AW(AW), .LEN_W(LEN_W), .ERR_W(ERR_W)) chk_i (.*);

// File: tb/txdesc_walker_tb_top.sv
`timescale 1ns/1ps
module txdesc_walker_tb_top;
   localparam int AW = 32;
   localparam int LEN_W = 13;
   localparam int ERR_W = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [AW-1:0]    base_addr = '0;
   logic             poll_demand = 1'b0;
   logic             rd_req, rd_ack;
   logic [AW-1:0]    rd_addr;
   logic [31:0]      rd_data;
   logic             seg_valid, seg_ready, seg_first, seg_last;
   logic [AW-1:0]    seg_buf1_addr, seg_buf2_addr;
   logic [LEN_W-1:0] seg_buf1_len, seg_buf2_len;
   logic             xfer_done;
   logic [ERR_W-1:0] xfer_err;
   logic             wr_req, wr_ack;
   logic [AW-1:0]    wr_addr;
   logic [31:0]      wr_data;
   logic             tx_irq, buf_unavail, busy;

   txdesc_walker #(.AW(AW), .LEN_W(LEN_W), .ERR_W(ERR_W)) dut_i (.*);

   // memory and fetcher models
   logic [31:0]      mem [0:255];
   logic             hw_en = 1'b0;
   logic [7:0]       hw_idx = '0;
   logic [31:0]      hw_dat = '0;
   logic [ERR_W-1:0] err_pat = '0;
   logic [2:0]       pend;

   assign xfer_err = err_pat;

   always @(posedge clk) begin
      if (!rst_n) begin
         rd_ack <= 1'b0; wr_ack <= 1'b0; seg_ready <= 1'b0;
         xfer_done <= 1'b0; pend <= '0; rd_data <= '0;
      end else begin
         rd_ack  <= rd_req && !rd_ack;
         rd_data <= mem[rd_addr[9:2]];
         wr_ack  <= wr_req && !wr_ack;
         xfer_done <= 1'b0;
         if (seg_valid && seg_ready) begin
            seg_ready <= 1'b0;
            pend <= 3'd3;
         end else if (seg_valid) begin
            seg_ready <= 1'b1;
         end
         if (pend != 0) begin
            pend <= pend - 1'b1;
            if (pend == 3'd1) xfer_done <= 1'b1;
         end
      end
      if (wr_req && !wr_ack && rst_n) mem[wr_addr[9:2]] <= wr_data;
      else if (hw_en) mem[hw_idx] <= hw_dat;
   end

   // monitors
   logic        clr_log = 1'b0;
   int          rd_cnt, seg_cnt, wr_cnt, irq_cnt;
   logic [31:0] rd_log [0:63];
   logic [31:0] s_b1a, s_b2a, s_wra, s_wrd;
   logic [15:0] s_l1, s_l2;
   logic        s_fs, s_ls;

   always @(negedge clk) begin
      if (clr_log) begin
         rd_cnt = 0; seg_cnt = 0; wr_cnt = 0; irq_cnt = 0;
      end else if (rst_n) begin
         if (rd_req && rd_ack) begin
            if (rd_cnt < 64) rd_log[rd_cnt] = rd_addr;
            rd_cnt++;
         end
         if (seg_valid && seg_ready) begin
            seg_cnt++;
            s_b1a = seg_buf1_addr; s_b2a = seg_buf2_addr;
            s_l1 = 16'(seg_buf1_len); s_l2 = 16'(seg_buf2_len);
            s_fs = seg_first; s_ls = seg_last;
         end
         if (wr_req && wr_ack) begin
            wr_cnt++; s_wra = wr_addr; s_wrd = wr_data;
         end
         if (tx_irq) irq_cnt++;
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk);
      hw_en = 1'b1; hw_idx = 8'(a >> 2); hw_dat = d;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   task automatic clear_logs();
      @(negedge clk); clr_log = 1'b1;
      @(negedge clk); clr_log = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse_start(input logic [31:0] b);
      @(negedge clk); base_addr = b; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_poll();
      @(negedge clk); poll_demand = 1'b1;
      @(negedge clk); poll_demand = 1'b0;
   endtask

   task automatic wait_susp(input string req);
      int n = 0;
      @(negedge clk);
      while (!buf_unavail && n < 3000) begin
         @(negedge clk); n++;
      end
      chk(buf_unavail, req, {31'b0, buf_unavail}, 32'd1);
   endtask

   localparam logic [31:0] OWN = 32'h8000_0000, IC = 32'h4000_0000, LS = 32'h2000_0000,
                           FS = 32'h1000_0000, EOR = 32'h0020_0000, CHN = 32'h0010_0000;

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 256; i++) poke(i * 4, 32'h0);
      do_reset();
      clear_logs();
      // reset state
      chk(!rd_req && !seg_valid && !wr_req, "R1 reset quiet", {29'b0, rd_req, seg_valid, wr_req}, 0);
      chk(!buf_unavail && !tx_irq && !busy, "R2 reset flags", {29'b0, buf_unavail, tx_irq, busy}, 0);

      // ring walk: plain, chained-without-first, end-of-ring
      poke(32'h100, OWN | FS);        poke(32'h104, 32'h0011_0022);
      poke(32'h108, 32'h0000_2000);   poke(32'h10C, 32'h0000_2100);
      poke(32'h110, OWN | IC | LS | CHN); poke(32'h114, 32'h0033_0044);
      poke(32'h118, 32'h0000_2200);   poke(32'h11C, 32'h0000_0300);
      poke(32'h120, OWN | FS | LS | EOR); poke(32'h124, 32'h0055_0066);
      poke(32'h128, 32'h0000_2300);   poke(32'h12C, 32'h0000_2400);
      err_pat = '0;
      pulse_start(32'h100);
      repeat (4) @(negedge clk);
      pulse_poll(); // R9: not suspended, must change nothing
      wait_susp("R2 ring suspends");
      chk(rd_cnt == 13, "R9 R1 ring read count", rd_cnt, 13);
      for (int i = 0; i < 13 && i < rd_cnt; i++) begin
         logic [31:0] e;
         e = (i == 12) ? 32'h100 : 32'h100 + 32'((i / 4) * 16 + (i % 4) * 4);
         chk(rd_log[i] == e, "R1 R6 R5 ring read order", rd_log[i], e);
      end
      chk(irq_cnt == 1, "R8 ring irq count", irq_cnt, 1);
      chk(seg_cnt == 3 && wr_cnt == 3, "R7 ring seg/wb count", seg_cnt * 16 + wr_cnt, 32'h33);

      // poll coinciding with a non-owned word 0
      clear_logs();
      pulse_poll();
      while (!(rd_req && rd_ack)) @(negedge clk);
      poll_demand = 1'b1;
      @(negedge clk); poll_demand = 1'b0;
      repeat (20) @(negedge clk);
      chk(rd_cnt == 1, "R9 coincident poll ignored", rd_cnt, 1);
      chk(buf_unavail, "R2 R9 still suspended", {31'b0, buf_unavail}, 1);
      // now owned: legitimate poll resumes at same descriptor
      poke(32'h100, OWN | FS | LS | IC | EOR);
      clear_logs();
      pulse_poll();
      wait_susp("R2 resume then suspend");
      chk(rd_cnt == 5 && rd_log[0] == 32'h100, "R2 refetch same address", rd_log[0], 32'h100);
      chk(rd_log[4] == 32'h100, "R5 wrap to base", rd_log[4], 32'h100);
      chk(seg_cnt == 1 && irq_cnt == 1, "R8 resumed irq", irq_cnt, 1);

      // sweep all flag combinations
      for (int c = 0; c < 32; c++) begin
         bit fs, ls, ic, chn, eor, ch_eff;
         logic [31:0] w0, w1, exp_wb, exp_nx;
         fs = c[0]; ls = c[1]; ic = c[2]; chn = c[3]; eor = c[4];
         ch_eff = fs && chn && !eor;
         w0 = OWN | (ic ? IC : 0) | (ls ? LS : 0) | (fs ? FS : 0) |
              (eor ? EOR : 0) | (chn ? CHN : 0) | 32'h0000_0005;
         w1 = ((32'h80 + 32'(c)) << 16) | (32'h40 + 32'(c));
         err_pat = (c[0] ^ c[2]) ? 4'b0100 : 4'b0000;
         exp_wb = (w0 & ~OWN) | ((c[0] ^ c[2]) ? 32'h0000_8000 : 0);
         exp_nx = eor ? 32'h200 : (ch_eff ? 32'h300 : 32'h210);
         for (int a = 32'h200; a < 32'h220; a += 4) poke(a, 32'h0);
         poke(32'h300, 32'h0);
         poke(32'h200, w0); poke(32'h204, w1);
         poke(32'h208, 32'h1000 + 32'(c * 16)); poke(32'h20C, 32'h300);
         do_reset();
         clear_logs();
         pulse_start(32'h200);
         wait_susp("R2 sweep suspend");
         chk(rd_cnt == 5 && rd_log[0] == 32'h200, "R1 sweep start at base", rd_log[0], 32'h200);
         chk(seg_cnt == 1 && s_fs == fs && s_ls == ls, "R3 sweep first/last",
             {30'b0, s_fs, s_ls}, {30'b0, fs, ls});
         chk(s_b1a == 32'h1000 + 32'(c * 16) && s_l1 == 16'(32'h40 + c), "R3 sweep buffer 1",
             s_b1a, 32'h1000 + 32'(c * 16));
         chk(s_b2a == 32'h300, "R3 sweep buffer 2 addr", s_b2a, 32'h300);
         chk(s_l2 == (ch_eff ? 16'h0 : 16'(32'h80 + c)), "R4 R6 sweep buffer 2 len",
             32'(s_l2), ch_eff ? 0 : 32'h80 + 32'(c));
         chk(wr_cnt == 1 && s_wra == 32'h200, "R7 sweep wb addr", s_wra, 32'h200);
         chk(s_wrd == exp_wb, "R7 sweep wb data", s_wrd, exp_wb);
         chk(irq_cnt == ((ic && ls) ? 1 : 0), "R8 sweep irq", irq_cnt, (ic && ls) ? 1 : 0);
         chk(rd_log[4] == exp_nx, "R4 R5 R6 sweep next address", rd_log[4], exp_nx);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule